// File: doc/BRIEF.md
# Display Adaptor Identification Target

This block is a small I2C target that lets a video source ask a dual-mode display adaptor what it is. A fast system clock samples the bus lines, finds START and STOP conditions, and decodes a fixed 7-bit device address. The target answers with a fixed identification text held in a 17-entry read-only table: the ASCII text "DP-HDMI ADAPTOR", the byte 0x04, and a closing 0xFF.

A host picks a starting offset with a short write: the address with R/W=0, then one offset byte. It then reads with R/W=1. While the host keeps acknowledging, the target sends one byte after another. It stays on the last entry once it gets there. A host may also skip the offset write and read at once. After a STOP that ends a read, the next read starts at the beginning of the table. The target drives SDA only through an open-drain pull-low output. Every change it makes to SDA waits a few system clocks after SCL falls, so the master sees hold time. An enable input turns the whole target off.

Top module: `adid_rom_target`

## Requirements
- R1: Only the address byte 0x80 (7-bit address 1000000b, write) or 0x81 (read) is acknowledged. Any other address byte gets no ACK, and all traffic up to the next START is ignored: no ACK, no data, no change to the pointer.
- R2: An acknowledged byte is answered by holding SDA low for the whole high phase of the ninth SCL clock. SDA is released at reset and whenever no ACK or zero data bit is due.
- R3: In a write, the first byte after the address loads the read pointer. A STOP after it keeps that offset for the next read.
- R4: Table offsets 0x00 to 0x0F return 44 50 2D 48 44 4D 49 20 41 44 41 50 54 4F 52 04. Offset 0x10 returns 0xFF. Data bits go out most significant bit first.
- R5: A master ACK after a data byte makes the target send the byte at the next offset.
- R6: After offset 0x10 the pointer stays there, so every further ACK returns 0xFF. An offset written above 0x10 acts as 0x10.
- R7: A master NACK ends the read. The target releases SDA and stays silent through any further clocks until STOP or START.
- R8: A read that starts right after reset, or after a STOP that ended an earlier read, begins at offset 0x00.
- R9: Data bytes written after the offset byte are acknowledged and discarded. They leave the pointer unchanged.
- R10: While enable is low, the target never pulls SDA, and bus traffic has no effect on the pointer.
- R11: The SDA pull-low output changes only while SCL is low.
- R12: A repeated START is detected in any state and returns the target to address receive. A write of an offset followed by a repeated START and a read address reads from that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | High to take part in bus traffic |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_pull_low | output | 1 | High to pull SDA low (open-drain) |

## Verification
The pointer advance that follows a master ACK and the clamp at the last table entry are decided on the same SCL falling edge. That falling edge also loads the next transmit byte from the table. The case is provoked by reads that start at 0x0E and 0x0F, which cross the end of the table, and by reads that start at 0x10 and above. The result is judged by the exact byte sequence against the table that R4 and R6 define. A second meeting is a STOP that arrives while the target is waiting after a NACK: the read ends and the pointer resets in one step. A fast read afterwards must start at 0x44.

// File: rtl/adid_pkg.sv
`timescale 1ns/1ps
package adid_pkg;

    localparam int unsigned TBL_DEPTH     = 17;
    localparam int unsigned PTR_W         = $clog2(TBL_DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(TBL_DEPTH - 1);
    localparam int unsigned BITS_PER_BYTE = 8;
    localparam int unsigned CNT_W         = $clog2(BITS_PER_BYTE + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT_STOP
    } bus_state_e;

    typedef struct packed {
        bus_state_e       state;
        logic [CNT_W-1:0] bit_cnt;
        logic [7:0]       shreg;
        logic             rnw;
        logic             first_wr;
        logic [PTR_W-1:0] ptr;
        logic             mst_ack;
    } ctl_t;

endpackage

// File: rtl/adid_bus_sampler.sv
`timescale 1ns/1ps
// Synchronizes SCL/SDA and derives edge and bus-condition strobes.
module adid_bus_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev_q;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    // lvl[1] = SCL, lvl[0] = SDA
    assign sda_s     = lvl[0];
    assign scl_rise  = lvl[1] & ~prev_q[1];
    assign scl_fall  = ~lvl[1] & prev_q[1];
    assign start_det = lvl[1] & prev_q[1] & prev_q[0] & ~lvl[0];
    assign stop_det  = lvl[1] & prev_q[1] & ~prev_q[0] & lvl[0];

endmodule

// File: rtl/adid_id_table.sv
`timescale 1ns/1ps
// Fixed identification bytes; anything past the text reads as 0xFF.
module adid_id_table
    import adid_pkg::*;
(
    input  logic [PTR_W-1:0] idx,
    output logic [7:0]       data
);

    always_comb begin
        case (int'(idx))
            0:       data = 8'h44;
            1:       data = 8'h50;
            2:       data = 8'h2D;
            3:       data = 8'h48;
            4:       data = 8'h44;
            5:       data = 8'h4D;
            6:       data = 8'h49;
            7:       data = 8'h20;
            8:       data = 8'h41;
            9:       data = 8'h44;
            10:      data = 8'h41;
            11:      data = 8'h50;
            12:      data = 8'h54;
            13:      data = 8'h4F;
            14:      data = 8'h52;
            15:      data = 8'h04;
            default: data = 8'hFF;
        endcase
    end

endmodule

// File: rtl/adid_drive_timer.sv
`timescale 1ns/1ps
// Applies the requested SDA drive HOLD_CYC clocks after each SCL fall.
module adid_drive_timer #(
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fall,
    input  logic clear,
    input  logic want,
    output logic drive
);

    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] cnt_d, cnt_q;
    logic          drv_d, drv_q;

    always_comb begin
        cnt_d = cnt_q;
        drv_d = drv_q;
        if (!enable || clear) begin
            cnt_d = '0;
            drv_d = 1'b0;
        end else if (fall) begin
            cnt_d = HW'(HOLD_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == HW'(1)) drv_d = want;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            drv_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            drv_q <= drv_d;
        end
    end

    assign drive = drv_q;

endmodule

// File: rtl/adid_rom_target.sv
`timescale 1ns/1ps
// I2C target serving a fixed adaptor identification table.
module adid_rom_target
    import adid_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h40,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_CYC    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull_low
);

    localparam ctl_t CTL_RST = '{
        state:    ST_IDLE,
        bit_cnt:  '0,
        shreg:    '0,
        rnw:      1'b0,
        first_wr: 1'b0,
        ptr:      '0,
        mst_ack:  1'b0
    };

    logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
    ctl_t             ctl_d, ctl_q;
    logic [PTR_W-1:0] ptr_adv, wr_ofs, tbl_idx;
    logic [7:0]       tbl_data;
    logic             want;

    adid_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    // Next pointer after a master ACK, clamped at the last entry.
    assign ptr_adv = (ctl_q.ptr == PTR_LAST) ? PTR_LAST : ctl_q.ptr + 1'b1;
    // Written offset, clamped so every out-of-range offset reads 0xFF.
    assign wr_ofs  = (ctl_q.shreg > 8'(PTR_LAST)) ? PTR_LAST : ctl_q.shreg[PTR_W-1:0];
    assign tbl_idx = (ctl_q.state == ST_RD_ACK) ? ptr_adv : ctl_q.ptr;

    adid_id_table u_table (
        .idx (tbl_idx),
        .data(tbl_data)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!enable) begin
            ctl_d.state   = ST_IDLE;
            ctl_d.bit_cnt = '0;
        end else if (start_det) begin
            ctl_d.state   = ST_ADDR;
            ctl_d.bit_cnt = '0;
        end else if (stop_det) begin
            if (ctl_q.state inside {ST_RD_BYTE, ST_RD_ACK, ST_WAIT_STOP}) begin
                ctl_d.ptr = '0;
            end
            ctl_d.state   = ST_IDLE;
            ctl_d.bit_cnt = '0;
        end else begin
            case (ctl_q.state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        ctl_d.shreg   = {ctl_q.shreg[6:0], sda_s};
                        ctl_d.bit_cnt = ctl_q.bit_cnt + 1'b1;
                    end else if (scl_fall && ctl_q.bit_cnt == CNT_W'(BITS_PER_BYTE)) begin
                        ctl_d.bit_cnt = '0;
                        if (ctl_q.state == ST_ADDR) begin
                            if (ctl_q.shreg[7:1] == DEV_ADDR) begin
                                ctl_d.state = ST_ADDR_ACK;
                                ctl_d.rnw   = ctl_q.shreg[0];
                            end else begin
                                ctl_d.state = ST_IDLE;
                            end
                        end else begin
                            ctl_d.state    = ST_WR_ACK;
                            ctl_d.first_wr = 1'b0;
                            if (ctl_q.first_wr) ctl_d.ptr = wr_ofs;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        ctl_d.bit_cnt = '0;
                        if (ctl_q.rnw) begin
                            ctl_d.state = ST_RD_BYTE;
                            ctl_d.shreg = tbl_data;
                        end else begin
                            ctl_d.state    = ST_WR_BYTE;
                            ctl_d.first_wr = 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        ctl_d.state   = ST_WR_BYTE;
                        ctl_d.bit_cnt = '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (ctl_q.bit_cnt == CNT_W'(BITS_PER_BYTE - 1)) begin
                            ctl_d.state   = ST_RD_ACK;
                            ctl_d.bit_cnt = '0;
                        end else begin
                            ctl_d.shreg   = {ctl_q.shreg[6:0], 1'b0};
                            ctl_d.bit_cnt = ctl_q.bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        ctl_d.mst_ack = ~sda_s;
                    end else if (scl_fall) begin
                        if (ctl_q.mst_ack) begin
                            ctl_d.state = ST_RD_BYTE;
                            ctl_d.ptr   = ptr_adv;
                            ctl_d.shreg = tbl_data;
                        end else begin
                            ctl_d.state = ST_WAIT_STOP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (ctl_q.state)
            ST_ADDR_ACK, ST_WR_ACK: want = 1'b1;
            ST_RD_BYTE:             want = ~ctl_q.shreg[7];
            default:                want = 1'b0;
        endcase
    end

    adid_drive_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(enable),
        .fall  (scl_fall),
        .clear (start_det | stop_det),
        .want  (want),
        .drive (sda_pull_low)
    );

endmodule

// File: rtl/adid_rom_target_chk.sv
`timescale 1ns/1ps
module adid_rom_target_chk
    import adid_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             sda_pull_low,
    input logic             scl_rise,
    input logic             scl_fall,
    input bus_state_e       state,
    input logic [PTR_W-1:0] ptr
);

    logic scl_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        scl_hi_q <= 1'b1;
        else if (scl_rise) scl_hi_q <= 1'b1;
        else if (scl_fall) scl_hi_q <= 1'b0;
    end

    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sda_pull_low);

    a_r1_silent_on_address: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ADDR) |-> !sda_pull_low);

    a_r2_ack_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR_ACK || state == ST_WR_ACK) && scl_hi_q) |-> sda_pull_low);

    a_r7_quiet_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_STOP) |-> !sda_pull_low);

    a_r11_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && scl_hi_q && $past(scl_hi_q)) |-> $stable(sda_pull_low));

    a_r6_ptr_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_LAST);

endmodule

bind adid_rom_target adid_rom_target_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .sda_pull_low(sda_pull_low),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .state       (ctl_q.state),
    .ptr         (ctl_q.ptr)
);

// File: tb/tb_adid_rom_target.sv
`timescale 1ns/1ps
module tb_adid_rom_target;

    localparam int Q = 12;  // system clocks per quarter SCL bit

    typedef struct packed {
        logic       wr;
        logic [7:0] off;
        logic [4:0] cnt;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 8'h00, 5'd3},
        '{1'b1, 8'h05, 5'd2},
        '{1'b0, 8'h00, 5'd2},
        '{1'b1, 8'h0E, 5'd4},
        '{1'b1, 8'h0F, 5'd3},
        '{1'b1, 8'h20, 5'd2},
        '{1'b1, 8'h10, 5'd1},
        '{1'b1, 8'h08, 5'd8}
    };

    logic clk = 1'b0;
    logic rst_n, enable, scl_m, sda_m;
    logic sda_pull_low;
    wire  sda_bus = sda_m & ~sda_pull_low;

    int n_run = 0, n_fail = 0;
    int glitches = 0, hi_changes = 0, off_drive = 0;
    bit done = 1'b0;
    logic scl_prev = 1'b1, pull_prev = 1'b0;

    always #10 clk = ~clk;

    adid_rom_target dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .scl_in      (scl_m),
        .sda_in      (sda_bus),
        .sda_pull_low(sda_pull_low)
    );

    always @(negedge clk) begin
        if (rst_n === 1'b1 && scl_m && scl_prev && sda_pull_low !== pull_prev) hi_changes++;
        if (enable === 1'b0 && sda_pull_low === 1'b1) off_drive++;
        scl_prev  = scl_m;
        pull_prev = sda_pull_low;
    end

    function automatic logic [7:0] exp_byte(int off);
        string t = "DP-HDMI ADAPTOR";
        if (off < 15)  return t[off];
        if (off == 15) return 8'h04;
        return 8'hFF;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    // One SCL clock; returns line level early and late in the high phase.
    task automatic bit_xfer(input logic b, output logic s_early, output logic s_late);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2);
        s_early = sda_bus;
        tick(2 * Q - 3);
        s_late = sda_bus;
        if (s_early !== s_late && b) glitches++;
        tick(1);
        scl_m = 1'b0; tick(Q - 2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic e, l;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], e, l);
        bit_xfer(1'b1, e, l);
        acked = !e && !l;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        logic e, l;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, e, l);
            b[i] = e;
        end
        bit_xfer(!mack, e, l);
    endtask

    task automatic read_seq(int n, int first, string tag0);
        logic       a;
        logic [7:0] b;
        string      tag;
        bus_start();
        send_byte(8'h81, a);
        check("R2", "read address ACK", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k != n - 1);
            tag = (first + k >= 16) ? "R6" : ((k == 0) ? tag0 : "R5");
            check(tag, $sformatf("byte at offset %0d", first + k), b, exp_byte(first + k));
        end
        tick(Q);
        check("R7", "SDA released after NACK", sda_pull_low, 0);
        bus_stop();
        tick(Q);
    endtask

    task automatic write_offset(logic [7:0] off, bit do_stop);
        logic a;
        bus_start();
        send_byte(8'h80, a);
        check("R1", "write address ACK", a, 1);
        send_byte(off, a);
        check("R3", "offset byte ACK", a, 1);
        if (do_stop) begin
            bus_stop();
            tick(Q);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R11 watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] b;
        rst_n = 1'b0; enable = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
        tick(5);
        check("R2", "SDA released in reset", sda_pull_low, 0);
        rst_n = 1'b1;
        tick(5);
        check("R2", "SDA released after reset", sda_pull_low, 0);

        // R8: fast read straight after reset starts at offset 0
        read_seq(1, 0, "R8");

        // Vector walk: optional offset write, then a read of cnt bytes
        for (int v = 0; v < 8; v++) begin
            if (VECS[v].wr) write_offset(VECS[v].off, 1'b1);
            read_seq(int'(VECS[v].cnt), VECS[v].wr ? int'(VECS[v].off) : 0,
                     VECS[v].wr ? "R3" : "R8");
        end

        // R1: foreign addresses are not answered and leave the pointer alone
        bus_start();
        send_byte(8'h82, a);
        check("R1", "foreign write address ACK", a, 0);
        send_byte(8'h07, a);
        check("R1", "byte after foreign address ACK", a, 0);
        bus_stop();
        tick(Q);
        bus_start();
        send_byte(8'hA1, a);
        check("R1", "foreign read address ACK", a, 0);
        recv_byte(b, 1'b0);
        check("R1", "no data for foreign read", b, 8'hFF);
        bus_stop();
        tick(Q);
        read_seq(1, 0, "R1");

        // R9: extra write bytes acknowledged and dropped
        write_offset(8'h03, 1'b0);
        send_byte(8'h77, a);
        check("R9", "extra byte ACK", a, 1);
        send_byte(8'h66, a);
        check("R9", "second extra byte ACK", a, 1);
        bus_stop();
        tick(Q);
        read_seq(2, 3, "R9");

        // R12: offset write then repeated START into a read
        write_offset(8'h09, 1'b0);
        read_seq(1, 9, "R12");

        // R7: after NACK the target stays silent through further clocks
        bus_start();
        send_byte(8'h81, a);
        check("R2", "read address ACK", a, 1);
        recv_byte(b, 1'b0);
        check("R4", "first byte before NACK", b, 8'h44);
        recv_byte(b, 1'b0);
        check("R7", "silent after NACK", b, 8'hFF);
        bus_stop();
        tick(Q);
        read_seq(1, 0, "R8");

        // R10: traffic while disabled is ignored
        enable = 1'b0;
        tick(Q);
        bus_start();
        send_byte(8'h80, a);
        check("R10", "no ACK while disabled", a, 0);
        send_byte(8'h02, a);
        check("R10", "offset not ACKed while disabled", a, 0);
        bus_stop();
        tick(Q);
        enable = 1'b1;
        tick(Q);
        read_seq(1, 0, "R10");
        check("R10", "drive events while disabled", off_drive, 0);

        check("R11", "SDA output changes while SCL high", hi_changes, 0);
        check("R11", "line changes inside high phase", glitches, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule